// File: doc/BRIEF.md
# Write-Update Snooping Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared broadcast bus. It keeps coherent copies of memory words by write-update rather than invalidation. A line is either invalid or holds a clean copy, because the cache is write-through and never holds data that memory lacks. The processor sees a load/store port with a stall output. On the bus side the cache has a request/grant pair, a one-cycle command it drives while granted, a read-response input from memory and a snoop input that carries every write broadcast on the bus.

A store never writes the cache array directly. The store waits for the bus and is driven onto it in the grant cycle. The processor is released on the next cycle. The cache changes its own copy only when that write comes back on the snoop input, just as it does for writes from other agents. A snooped write updates a resident line with a matching tag and is otherwise dropped. A load that misses fetches the word over the bus, fills the line and then releases the processor. The cache does not allocate a line on a store.

Top module: `snoop_wu_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address misses. With no request pending, `cpu_stall`, `bus_req` and `bus_drv_valid` are low.
- R2: A load whose index holds a valid line with a matching tag does not stall. It returns the line's data on `cpu_rdata` in the same cycle.
- R3: A load miss stalls and raises `bus_req`. In the grant cycle it drives a read (`bus_drv_we`=0) of the load address. The line is filled from `mem_rdata` in the cycle `mem_rvalid` is high. In the following cycle the stall is low and `cpu_rdata` holds the word. A later load to that address hits.
- R4: A store stalls until the bus grants it. In the grant cycle it drives `bus_drv_we`=1 with the store's address and data. The stall drops in the cycle after the grant.
- R5: A store changes the cache contents only through the snoop input. If the broadcast is not reflected back, a later load hit returns the old value.
- R6: A snooped write whose address matches a valid resident line replaces that line's data. This also holds while a fill to another index is in progress.
- R7: A snooped write that misses the cache is ignored. It does not allocate a line, so a later load to that address still misses.
- R8: If a fill and a snooped write hit the same index in one cycle, the snooped data is written when the two addresses are equal. When the addresses differ, the fill wins and the snooped address stays non-resident.
- R9: `bus_req` stays high from the cycle after the request until the grant. The command on `bus_drv_*` is valid only in the one granted cycle. Both request and command are low in the cycle after it.
- R10: A store to an address that is not resident does not allocate a line. A store to a resident address does not change which tag the line holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when a load request sees stall low |
| cpu_stall | output | 1 | Processor must hold its request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant; the command is driven in this cycle |
| bus_drv_valid | output | 1 | Command valid (only while granted) |
| bus_drv_we | output | 1 | 1 = write broadcast, 0 = read |
| bus_drv_addr | output | ADDR_W | Command address |
| bus_drv_data | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | DATA_W | Memory read response data |
| snp_valid | input | 1 | A write is broadcast on the bus this cycle |
| snp_addr | input | ADDR_W | Broadcast write address |
| snp_data | input | DATA_W | Broadcast write data |

## Verification
The bench builds the cache with ADDR_W=6, IDX_W=2 and DATA_W=8. That gives four lines and a 64-word address space, so every address can be loaded, stored and snooped in full passes. Each line is displaced by each of its sixteen tags in turn. A bench-side memory array and residency table give the expected hit or miss and the data for every access. Grant delays of zero to three cycles are used. Fill-cycle snoops are placed on the same address, on the same index with another address, and on another resident index.

// File: rtl/snoop_wu_cache.sv
module snoop_wu_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_drv_valid,
  output logic              bus_drv_we,
  output logic [ADDR_W-1:0] bus_drv_addr,
  output logic [DATA_W-1:0] bus_drv_data,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {IDLE, BUS, FILL, DONE} st_t;
  st_t st, st_n;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  logic [IDX_W-1:0]  c_idx, s_idx, f_idx;
  logic [TAG_W-1:0]  c_tag, s_tag, f_tag;
  logic              hit, snp_hit, fill;
  logic [DATA_W-1:0] fill_data;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign f_idx = op_addr[IDX_W-1:0];
  assign f_tag = op_addr[ADDR_W-1:IDX_W];

  assign hit     = vld[c_idx] && (tag_q[c_idx] == c_tag);
  assign snp_hit = snp_valid && vld[s_idx] && (tag_q[s_idx] == s_tag);
  assign fill    = (st == FILL) && mem_rvalid;
  assign fill_data = (snp_valid && snp_addr == op_addr) ? snp_data : mem_rdata;

  assign cpu_rdata = dat_q[c_idx];
  assign cpu_stall = cpu_req && (st != DONE) && !(st == IDLE && !cpu_we && hit);

  assign bus_req       = (st == BUS);
  assign bus_drv_valid = (st == BUS) && bus_gnt;
  assign bus_drv_we    = op_we;
  assign bus_drv_addr  = op_addr;
  assign bus_drv_data  = op_data;

  always_comb begin
    st_n = st;
    case (st)
      IDLE: if (cpu_req && (cpu_we || !hit)) st_n = BUS;
      BUS:  if (bus_gnt) st_n = op_we ? DONE : FILL;
      FILL: if (mem_rvalid) st_n = DONE;
      DONE: st_n = IDLE;
      default: st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      op_we   <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st <= st_n;
      if (st == IDLE && st_n == BUS) begin
        op_we   <= cpu_we;
        op_addr <= cpu_addr;
        op_data <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (fill) vld[f_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (fill && f_idx == IDX_W'(i)) begin
        tag_q[i] <= f_tag;
        dat_q[i] <= fill_data;
      end else if (snp_hit && s_idx == IDX_W'(i)) begin
        dat_q[i] <= snp_data;
      end
    end
  end

  // R9
  one_shot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv_valid |=> !bus_drv_valid && !bus_req);

  // R4
  store_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall) |-> $past(bus_drv_valid && bus_drv_we));

  // R7
  no_snoop_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fill) |-> $stable(vld));

  // R3
  fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill) |-> (st == DONE && !(cpu_req && cpu_stall)));

  // R9
  req_until_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
endmodule

// File: tb/tb_snoop_wu_cache.sv
module tb_snoop_wu_cache;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int N  = 1 << AW;
  localparam int L  = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_stall, bus_req, bus_gnt = 0;
  logic bus_drv_valid, bus_drv_we;
  logic [AW-1:0] bus_drv_addr;
  logic [DW-1:0] bus_drv_data;
  logic mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic snp_valid = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;

  snoop_wu_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_drv_valid(bus_drv_valid), .bus_drv_we(bus_drv_we),
    .bus_drv_addr(bus_drv_addr), .bus_drv_data(bus_drv_data),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data));

  always #5 clk = ~clk;

  logic [DW-1:0]    mem [N];
  logic             mv  [L];
  logic [AW-IW-1:0] mt  [L];
  int nvec = 0, nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input int a, input int gap, input bit sn, input int sa,
                         input int sd, input string tag);
    int i = a % L;
    int t = a / L;
    bit hit = mv[i] && (mt[i] == t);
    int exp;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = AW'(a);
    #1;
    if (hit) begin
      chk(cpu_stall == 0, {tag, " hit stall"}, cpu_stall, 0);
      chk(cpu_rdata == mem[a], {tag, " hit data"}, cpu_rdata, mem[a]);
    end else begin
      chk(cpu_stall == 1, {tag, " miss stall"}, cpu_stall, 1);
      @(negedge clk); #1;
      chk(bus_req == 1 && !bus_drv_valid, "R9 request raised", bus_req, 1);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
        chk(bus_req == 1 && !bus_drv_valid && cpu_stall, "R9 request held", bus_req, 1);
      end
      bus_gnt = 1; #1;
      chk(bus_drv_valid && !bus_drv_we && bus_drv_addr == AW'(a), "R3 read cmd",
          bus_drv_addr, a);
      @(negedge clk);
      bus_gnt = 0; #1;
      chk(!bus_drv_valid && !bus_req, "R9 one-cycle cmd", bus_drv_valid, 0);
      exp = mem[a];
      mem_rvalid = 1; mem_rdata = mem[a];
      if (sn) begin
        snp_valid = 1; snp_addr = AW'(sa); snp_data = DW'(sd);
        mem[sa] = DW'(sd);
        if (sa == a) exp = sd;
        if (mv[sa % L] && mt[sa % L] == sa / L && sa % L != i) begin end
      end
      #1;
      chk(cpu_stall == 1, "R3 stall during fill", cpu_stall, 1);
      @(negedge clk);
      mem_rvalid = 0; snp_valid = 0; #1;
      chk(cpu_stall == 0, {tag, " release"}, cpu_stall, 0);
      chk(cpu_rdata == DW'(exp), sn ? "R8 fill data" : "R3 fill data", cpu_rdata, exp);
      mv[i] = 1; mt[i] = (AW-IW)'(t);
    end
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic do_store(input int a, input int d, input int gap, input bit loopback);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = AW'(a); cpu_wdata = DW'(d);
    #1;
    chk(cpu_stall == 1, "R4 store stall", cpu_stall, 1);
    @(negedge clk); #1;
    chk(bus_req == 1, "R9 store request", bus_req, 1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); #1;
      chk(bus_req == 1 && !bus_drv_valid && cpu_stall, "R4 wait for grant", cpu_stall, 1);
    end
    bus_gnt = 1;
    if (loopback) begin
      snp_valid = 1; snp_addr = AW'(a); snp_data = DW'(d);
    end
    #1;
    chk(bus_drv_valid && bus_drv_we && bus_drv_addr == AW'(a) && bus_drv_data == DW'(d),
        "R4 write broadcast", bus_drv_data, d);
    @(negedge clk);
    bus_gnt = 0; snp_valid = 0;
    if (loopback) mem[a] = DW'(d);
    #1;
    chk(cpu_stall == 0 && !bus_req, "R4 store release", cpu_stall, 0);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic do_snoop(input int a, input int d);
    @(negedge clk);
    snp_valid = 1; snp_addr = AW'(a); snp_data = DW'(d);
    mem[a] = DW'(d);
    @(negedge clk);
    snp_valid = 0; #1;
    chk(!bus_req && !bus_drv_valid, "R7 snoop causes no bus traffic", bus_req, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int a = 0; a < N; a++) mem[a] = DW'(a * 7 + 3);
    for (int i = 0; i < L; i++) begin mv[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_stall == 0 && bus_req == 0 && bus_drv_valid == 0, "R1 reset outputs", cpu_stall, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(bus_req == 0, "R1 idle after reset", bus_req, 0);

    // R1 R2 R3: every address misses once, then hits
    for (int a = 0; a < N; a++) begin
      do_load(a, a % 3, 0, 0, 0, "R1");
      do_load(a, 0, 0, 0, 0, "R2");
    end

    // R6 R7: snoop every address; only resident lines take it
    for (int a = 0; a < N; a++) do_snoop(a, a ^ 8'h5A);
    for (int a = N - L; a < N; a++) do_load(a, 0, 0, 0, 0, "R6");
    for (int a = 0; a < N - L; a++) do_load(a, a % 2, 0, 0, 0, "R7");

    // R4 R10: stores with broadcast reflected, no allocation
    for (int a = 0; a < N; a++) do_store(a, a * 3 + 1, a % 4, 1);
    for (int a = 0; a < N; a++) do_load(a, 1, 0, 0, 0, "R10");

    // R5: broadcast not reflected, resident copy keeps the old value
    do_store(61, 8'hEE, 0, 0);
    do_load(61, 0, 0, 0, 0, "R5");

    // R8: same address, snoop wins
    do_load(1, 0, 1, 1, 8'h77, "R8");
    do_load(1, 0, 0, 0, 0, "R8");
    // R8: same index, other address, fill wins
    do_load(6, 2, 1, 2, 8'h33, "R8");
    do_load(2, 0, 0, 0, 0, "R8");
    // R6: snoop to another resident index during a fill
    do_load(5, 1, 1, 63, 8'hC4, "R6");
    do_load(63, 0, 0, 0, 0, "R6");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule